// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the privileged context of a small processor: the status word (privilege, register bank select, block flag and a 4-bit interrupt mask), a saved copy of that word, a saved return address and the vector base. Each cycle it looks at the pending event lines and decides whether one is taken. When an event is taken, the block saves context, raises the block flag and sends a one-cycle redirect to the fetch unit. When the return instruction's delay slot completes, the block restores the saved context and redirects to the saved return address.

While the block flag is set, the block acts as a guard. Break traps are dropped. Maskable interrupts wait, except when the core is in a low-power state. NMI gets through only if a separate mask-override bit is set. Any other exception jumps quietly to the fixed reset address, without touching the saved context and without the reset-out or state-code pins acting as they do for a real reset.

The sequencing is a three-state machine. ST_RESET is held during reset. It leaves through the *reset exit* transition (redirect to the reset address) into ST_RUN. In ST_RUN the *event entry* and *blocked exception* transitions both loop back to ST_RUN. The *return issue* transition moves from ST_RUN to ST_RTE_SLOT. From ST_RTE_SLOT, the *return complete* transition goes back to ST_RUN once the delay slot retires.

Top module: `exc_flow_ctrl`

## Requirements
- R1: While reset is asserted, `rst_out`=1 and `state_code`=2'b11, and the status word holds privilege=1, bank=1, block=1, mask=4'hF, with the vector base at 0. On the first clock after reset is released, `redir_vld`=1 and `redir_pc`=RESET_PC (default 32'hA000_0000), and `rst_out` has dropped to 0.
- R2: While block=1 and `low_power`=0, a maskable interrupt is not taken. When an SR write clears block in a cycle that also has `retire` high, the interrupt is still not taken in that cycle. It is taken at the next `retire`.
- R3: While `low_power`=1, a qualifying interrupt is taken even if block=1, and it needs no `retire`.
- R4: While block=1, NMI is taken only if `nmi_blmsk`=1. NMI, like a maskable interrupt, is taken only in a cycle with `retire` or `low_power` high.
- R5: While block=1, a break request has no effect: there is no redirect and the context is unchanged.
- R6: While block=1, a general exception redirects to RESET_PC. The saved word, saved PC, vector base and status word are left unchanged, and `rst_out` stays 0 with `state_code` not equal to 2'b11.
- R7: After `rte_req`, the next `retire` produces a redirect to the saved PC and copies the saved word into the status word.
- R8: A taken event copies the status word to the saved word, sets block=1 and privilege=1, and redirects one cycle later. The redirect goes to vector base + EXC_OFS for an exception or break, to vector base + INT_OFS for an interrupt, and to vector base + NMI_OFS for an NMI. The saved PC is `cur_pc` for an exception or break with `exc_reexec`=1, and `nxt_pc` in every other case.
- R9: When several events are pending in the same cycle, the winner follows a fixed order: exception first, then break, then NMI, then interrupt.
- R10: An interrupt is taken only if `irq_lvl` is strictly greater than the mask.
- R11: An exception or break raised while the return's delay slot is pending is not taken. It pulses `rte_slot_err` in the next cycle, and the return still completes at the slot's `retire`.
- R12: `cr_sel` picks the register to write: 0 is the status word, 1 the saved word, 2 the saved PC, 3 the vector base. In the status and saved words, bit 30 is privilege, bit 29 is bank, bit 28 is block and bits 7:4 are the mask. A write is dropped in any cycle where an event (taken or blocked) or a return completion updates the context.
- R13: `state_code` is 2'b11 in reset, 2'b01 when `low_power`=1 and 2'b00 otherwise. `redir_vld` lasts exactly one cycle per redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire | input | 1 | An instruction completed this cycle |
| cur_pc | input | 32 | PC of the current instruction |
| nxt_pc | input | 32 | PC of the following instruction |
| exc_req | input | 1 | General exception request |
| exc_reexec | input | 1 | Exception or break re-executes the faulting instruction |
| brk_req | input | 1 | User break trap request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| nmi_blmsk | input | 1 | Lets NMI through while block=1 |
| irq_req | input | 1 | Maskable interrupt request |
| irq_lvl | input | 4 | Level of the maskable interrupt |
| low_power | input | 1 | Core in sleep or standby |
| rte_req | input | 1 | Return instruction retired |
| cr_wr_en | input | 1 | Control register write |
| cr_sel | input | 2 | Control register select |
| cr_wr_data | input | 32 | Control register write data |
| redir_vld | output | 1 | PC redirect strobe |
| redir_pc | output | 32 | Redirect target |
| sr_md | output | 1 | Privilege bit |
| sr_bl | output | 1 | Block bit |
| sr_rb | output | 1 | Bank select bit |
| sr_imask | output | 4 | Interrupt mask |
| rst_out | output | 1 | Reset indication pin |
| state_code | output | 2 | Processor state code pins |
| rte_slot_err | output | 1 | Event raised in the return delay slot |

## Verification
The bench builds the block with NMI_OFS=32'h700, which differs from INT_OFS=32'h600, so the redirect address shows directly whether NMI or the interrupt won arbitration. RESET_PC and EXC_OFS keep their default values. The bench writes a non-zero vector base, which makes a redirect to the reset address easy to tell apart from an ordinary vectored entry. Saved words and saved PCs are observed through the return path: each `rte_req` followed by `retire` shows the saved PC on `redir_pc` and the saved word on the status outputs.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IMASK_W   = 4;
    localparam int unsigned SR_MD_BIT = 30;
    localparam int unsigned SR_RB_BIT = 29;
    localparam int unsigned SR_BL_BIT = 28;
    localparam int unsigned SR_IM_LSB = 4;

    typedef struct packed {
        logic               md;
        logic               rb;
        logic               bl;
        logic [IMASK_W-1:0] imask;
    } sr_t;

    typedef enum logic [1:0] {ST_RESET, ST_RUN, ST_RTE_SLOT} fsm_t;

    typedef enum logic [2:0] {
        EV_NONE, EV_EXC, EV_BRK, EV_NMI, EV_IRQ, EV_BLKEXC
    } ev_t;

    typedef enum logic [1:0] {CTX_HOLD, CTX_ENTRY, CTX_RTE, CTX_DROP} ctx_op_t;

    typedef enum logic [1:0] {CR_SR, CR_SSR, CR_SPC, CR_VBR} cr_sel_t;

    localparam sr_t SR_RESET = '{md: 1'b1, rb: 1'b1, bl: 1'b1, imask: {IMASK_W{1'b1}}};

    function automatic sr_t sr_unpack(input logic [WORD_W-1:0] w);
        sr_t s;
        s.md    = w[SR_MD_BIT];
        s.rb    = w[SR_RB_BIT];
        s.bl    = w[SR_BL_BIT];
        s.imask = w[SR_IM_LSB +: IMASK_W];
        return s;
    endfunction
endpackage

// File: rtl/exc_accept.sv
module exc_accept
    import exc_pkg::*;
(
    input  fsm_t               state,
    input  sr_t                sr,
    input  logic               retire,
    input  logic               low_power,
    input  logic               exc_req,
    input  logic               brk_req,
    input  logic               nmi_req,
    input  logic               nmi_blmsk,
    input  logic               irq_req,
    input  logic [IMASK_W-1:0] irq_lvl,
    output ev_t                kind,
    output logic               slot_err
);
    logic boundary;
    logic irq_ok;
    logic nmi_ok;
    logic brk_ok;

    always_comb begin
        boundary = retire || low_power;
        irq_ok   = irq_req && boundary && (irq_lvl > sr.imask) && (!sr.bl || low_power);
        nmi_ok   = nmi_req && boundary && (!sr.bl || nmi_blmsk);
        brk_ok   = brk_req && !sr.bl;
        kind     = EV_NONE;
        slot_err = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (exc_req)     kind = sr.bl ? EV_BLKEXC : EV_EXC;
                else if (brk_ok) kind = EV_BRK;
                else if (nmi_ok) kind = EV_NMI;
                else if (irq_ok) kind = EV_IRQ;
            end
            ST_RTE_SLOT: slot_err = exc_req || brk_req;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [WORD_W-1:0] EXC_OFS  = 32'h0000_0100,
    parameter logic [WORD_W-1:0] INT_OFS  = 32'h0000_0600,
    parameter logic [WORD_W-1:0] NMI_OFS  = 32'h0000_0600
) (
    input  ev_t               kind,
    input  logic [WORD_W-1:0] vbr,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [WORD_W-1:0] nxt_pc,
    input  logic              exc_reexec,
    output logic [WORD_W-1:0] tgt_pc,
    output logic [WORD_W-1:0] ret_pc
);
    always_comb begin
        tgt_pc = RESET_PC;
        ret_pc = nxt_pc;
        unique case (kind)
            EV_EXC, EV_BRK: begin
                tgt_pc = vbr + EXC_OFS;
                ret_pc = exc_reexec ? cur_pc : nxt_pc;
            end
            EV_NMI:    tgt_pc = vbr + NMI_OFS;
            EV_IRQ:    tgt_pc = vbr + INT_OFS;
            EV_BLKEXC: tgt_pc = RESET_PC;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctx_op_t           op,
    input  logic [WORD_W-1:0] ret_pc,
    input  logic              cr_wr_en,
    input  logic [1:0]        cr_sel,
    input  logic [WORD_W-1:0] cr_wr_data,
    output sr_t               sr,
    output sr_t               ssr,
    output logic [WORD_W-1:0] spc,
    output logic [WORD_W-1:0] vbr
);
    sr_t               sr_q;
    sr_t               ssr_q;
    logic [WORD_W-1:0] spc_q;
    logic [WORD_W-1:0] vbr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= SR_RESET;
            ssr_q <= '0;
            spc_q <= '0;
            vbr_q <= '0;
        end else begin
            unique case (op)
                CTX_ENTRY: begin
                    ssr_q <= sr_q;
                    spc_q <= ret_pc;
                    sr_q  <= '{md: 1'b1, rb: sr_q.rb, bl: 1'b1, imask: sr_q.imask};
                end
                CTX_RTE:  sr_q <= ssr_q;
                CTX_DROP: ;
                default: begin
                    if (cr_wr_en) begin
                        unique case (cr_sel_t'(cr_sel))
                            CR_SR:  sr_q  <= sr_unpack(cr_wr_data);
                            CR_SSR: ssr_q <= sr_unpack(cr_wr_data);
                            CR_SPC: spc_q <= cr_wr_data;
                            CR_VBR: vbr_q <= cr_wr_data;
                        endcase
                    end
                end
            endcase
        end
    end

    assign sr  = sr_q;
    assign ssr = ssr_q;
    assign spc = spc_q;
    assign vbr = vbr_q;

    // R8
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CTX_ENTRY) |=> (ssr_q == $past(sr_q)) && (spc_q == $past(ret_pc)) && sr_q.bl && sr_q.md);

    // R7
    rte_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CTX_RTE) |=> (sr_q == $past(ssr_q)));

    // R12
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CTX_ENTRY || op == CTX_DROP) |=> $stable(vbr_q));

    // R6
    blk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CTX_DROP) |=> $stable(ssr_q) && $stable(spc_q) && $stable(sr_q));
endmodule

// File: rtl/exc_flow_ctrl.sv
module exc_flow_ctrl
    import exc_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [WORD_W-1:0] EXC_OFS  = 32'h0000_0100,
    parameter logic [WORD_W-1:0] INT_OFS  = 32'h0000_0600,
    parameter logic [WORD_W-1:0] NMI_OFS  = 32'h0000_0600
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               retire,
    input  logic [WORD_W-1:0]  cur_pc,
    input  logic [WORD_W-1:0]  nxt_pc,
    input  logic               exc_req,
    input  logic               exc_reexec,
    input  logic               brk_req,
    input  logic               nmi_req,
    input  logic               nmi_blmsk,
    input  logic               irq_req,
    input  logic [IMASK_W-1:0] irq_lvl,
    input  logic               low_power,
    input  logic               rte_req,
    input  logic               cr_wr_en,
    input  logic [1:0]         cr_sel,
    input  logic [WORD_W-1:0]  cr_wr_data,
    output logic               redir_vld,
    output logic [WORD_W-1:0]  redir_pc,
    output logic               sr_md,
    output logic               sr_bl,
    output logic               sr_rb,
    output logic [IMASK_W-1:0] sr_imask,
    output logic               rst_out,
    output logic [1:0]         state_code,
    output logic               rte_slot_err
);
    localparam logic [1:0] CODE_RESET = 2'b11;
    localparam logic [1:0] CODE_SLEEP = 2'b01;
    localparam logic [1:0] CODE_RUN   = 2'b00;

    fsm_t              state_q, state_d;
    ev_t               kind;
    logic              slot_err;
    ctx_op_t           op;
    sr_t               sr, ssr;
    logic [WORD_W-1:0] spc, vbr, tgt_pc, ret_pc;
    logic              redir_d;
    logic [WORD_W-1:0] pc_d;
    logic              redir_q, err_q;
    logic [WORD_W-1:0] pc_q;

    exc_accept u_accept (
        .state     (state_q),
        .sr        (sr),
        .retire    (retire),
        .low_power (low_power),
        .exc_req   (exc_req),
        .brk_req   (brk_req),
        .nmi_req   (nmi_req),
        .nmi_blmsk (nmi_blmsk),
        .irq_req   (irq_req),
        .irq_lvl   (irq_lvl),
        .kind      (kind),
        .slot_err  (slot_err)
    );

    exc_target #(
        .RESET_PC (RESET_PC),
        .EXC_OFS  (EXC_OFS),
        .INT_OFS  (INT_OFS),
        .NMI_OFS  (NMI_OFS)
    ) u_target (
        .kind       (kind),
        .vbr        (vbr),
        .cur_pc     (cur_pc),
        .nxt_pc     (nxt_pc),
        .exc_reexec (exc_reexec),
        .tgt_pc     (tgt_pc),
        .ret_pc     (ret_pc)
    );

    exc_ctx_regs u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .ret_pc     (ret_pc),
        .cr_wr_en   (cr_wr_en),
        .cr_sel     (cr_sel),
        .cr_wr_data (cr_wr_data),
        .sr         (sr),
        .ssr        (ssr),
        .spc        (spc),
        .vbr        (vbr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Transitions and context operation
    always_comb begin
        state_d = state_q;
        op      = CTX_HOLD;
        redir_d = 1'b0;
        pc_d    = pc_q;
        unique case (state_q)
            ST_RESET: begin
                state_d = ST_RUN;
                redir_d = 1'b1;
                pc_d    = RESET_PC;
                op      = CTX_DROP;
            end
            ST_RUN: begin
                if (kind == EV_BLKEXC) begin
                    redir_d = 1'b1;
                    pc_d    = tgt_pc;
                    op      = CTX_DROP;
                end else if (kind != EV_NONE) begin
                    redir_d = 1'b1;
                    pc_d    = tgt_pc;
                    op      = CTX_ENTRY;
                end else if (rte_req) begin
                    state_d = ST_RTE_SLOT;
                end
            end
            ST_RTE_SLOT: begin
                if (retire && !slot_err) begin
                    state_d = ST_RUN;
                    redir_d = 1'b1;
                    pc_d    = spc;
                    op      = CTX_RTE;
                end
            end
            default: state_d = ST_RESET;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_q <= 1'b0;
            pc_q    <= RESET_PC;
            err_q   <= 1'b0;
        end else begin
            redir_q <= redir_d;
            pc_q    <= pc_d;
            err_q   <= slot_err;
        end
    end

    assign redir_vld    = redir_q;
    assign redir_pc     = pc_q;
    assign rte_slot_err = err_q;
    assign sr_md        = sr.md;
    assign sr_bl        = sr.bl;
    assign sr_rb        = sr.rb;
    assign sr_imask     = sr.imask;
    assign rst_out      = (state_q == ST_RESET);
    assign state_code   = (state_q == ST_RESET) ? CODE_RESET :
                          (low_power ? CODE_SLEEP : CODE_RUN);

    // R2
    blk_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr.bl && !low_power) |-> (kind != EV_IRQ));

    // R4
    blk_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr.bl && !nmi_blmsk) |-> (kind != EV_NMI));

    // R5
    blk_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr.bl |-> (kind != EV_BRK));

    // R6
    blk_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EV_BLKEXC) |=> (redir_vld && redir_pc == RESET_PC && !rst_out && state_code != CODE_RESET));

    // R9
    exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exc_req) |-> (kind == EV_EXC || kind == EV_BLKEXC));

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EV_IRQ) |-> (irq_lvl > sr.imask));

    // R11
    slot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RTE_SLOT && (exc_req || brk_req)) |=> (rte_slot_err && !redir_vld));

    // R13
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_vld && state_q != ST_RTE_SLOT && !rte_req && kind == EV_NONE) |=> !redir_vld);
endmodule

// File: tb/exc_flow_ctrl_tb.sv
module exc_flow_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire, exc_req, exc_reexec, brk_req, nmi_req, nmi_blmsk;
    logic        irq_req, low_power, rte_req, cr_wr_en;
    logic [31:0] cur_pc, nxt_pc, cr_wr_data;
    logic [3:0]  irq_lvl;
    logic [1:0]  cr_sel;
    logic        redir_vld, sr_md, sr_bl, sr_rb, rst_out, rte_slot_err;
    logic [31:0] redir_pc;
    logic [3:0]  sr_imask;
    logic [1:0]  state_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] VB = 32'h8000_0000;

    always #2.5 clk = ~clk;

    exc_flow_ctrl #(.NMI_OFS(32'h0000_0700)) u_dut (
        .clk(clk), .rst_n(rst_n), .retire(retire), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .exc_req(exc_req), .exc_reexec(exc_reexec), .brk_req(brk_req), .nmi_req(nmi_req),
        .nmi_blmsk(nmi_blmsk), .irq_req(irq_req), .irq_lvl(irq_lvl), .low_power(low_power),
        .rte_req(rte_req), .cr_wr_en(cr_wr_en), .cr_sel(cr_sel), .cr_wr_data(cr_wr_data),
        .redir_vld(redir_vld), .redir_pc(redir_pc), .sr_md(sr_md), .sr_bl(sr_bl),
        .sr_rb(sr_rb), .sr_imask(sr_imask), .rst_out(rst_out), .state_code(state_code),
        .rte_slot_err(rte_slot_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        retire = 0; exc_req = 0; exc_reexec = 0; brk_req = 0; nmi_req = 0; nmi_blmsk = 0;
        irq_req = 0; irq_lvl = 0; low_power = 0; rte_req = 0; cr_wr_en = 0; cr_sel = 0;
        cr_wr_data = 0; cur_pc = 32'h100; nxt_pc = 32'h102;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] srw(bit md, bit rb, bit bl, logic [3:0] im);
        return (32'(md) << 30) | (32'(rb) << 29) | (32'(bl) << 28) | (32'(im) << 4);
    endfunction

    task automatic cr_write(input logic [1:0] sel, input logic [31:0] d);
        idle(); cr_wr_en = 1; cr_sel = sel; cr_wr_data = d;
        tick(); idle();
    endtask

    task automatic do_return(input string tag, input logic [31:0] exp_pc);
        idle(); rte_req = 1; tick();
        check({tag, " rte issue no redirect"}, 32'(redir_vld), 0);
        idle(); retire = 1; tick();
        check({tag, " rte redirect"}, 32'(redir_vld), 1);
        check({tag, " rte pc"}, redir_pc, exp_pc);
        idle();
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        repeat (3) tick();
        check("R1 rst_out", 32'(rst_out), 1);
        check("R1 state_code", 32'(state_code), 2'b11);
        check("R1 sr fields", {28'(0), sr_md, sr_rb, sr_bl, 1'b0}, 32'hE);
        check("R1 imask", 32'(sr_imask), 4'hF);
        rst_n = 1; tick();
        check("R1 reset redirect", 32'(redir_vld), 1);
        check("R1 reset pc", redir_pc, 32'hA000_0000);
        check("R1 rst_out released", 32'(rst_out), 0);
        tick();
        check("R13 single pulse", 32'(redir_vld), 0);
    endtask

    task automatic t_irq_block();
        cr_write(2'd3, VB);
        cr_write(2'd0, srw(1, 1, 1, 0));
        irq_req = 1; irq_lvl = 5; retire = 1; tick();
        check("R2 blocked irq", 32'(redir_vld), 0);
        cr_wr_en = 1; cr_sel = 0; cr_wr_data = srw(1, 1, 0, 0); tick();
        check("R2 not in clearing cycle", 32'(redir_vld), 0);
        check("R12 sr write bl", 32'(sr_bl), 0);
        cr_wr_en = 0; nxt_pc = 32'h1234; tick();
        check("R2 irq after clear", 32'(redir_vld), 1);
        check("R8 irq vector", redir_pc, VB + 32'h600);
        check("R8 entry bl md", {30'(0), sr_bl, sr_md}, 3);
        idle();
        do_return("R7", 32'h1234);
        check("R7 sr restored bl", 32'(sr_bl), 0);
        tick();
        check("R13 pulse after return", 32'(redir_vld), 0);
    endtask

    task automatic t_level();
        cr_write(2'd0, srw(1, 1, 0, 5));
        irq_req = 1; irq_lvl = 5; retire = 1; nxt_pc = 32'h3000; tick();
        check("R10 equal level ignored", 32'(redir_vld), 0);
        irq_lvl = 6; tick();
        check("R10 higher level taken", 32'(redir_vld), 1);
        check("R10 vector", redir_pc, VB + 32'h600);
        idle();
    endtask

    task automatic t_low_power();
        irq_req = 1; irq_lvl = 9; retire = 1; tick();
        check("R2 bl holds irq", 32'(redir_vld), 0);
        idle(); irq_req = 1; irq_lvl = 9; low_power = 1; nxt_pc = 32'h4000;
        #1 check("R13 sleep code", 32'(state_code), 2'b01);
        tick();
        check("R3 low-power irq", 32'(redir_vld), 1);
        check("R3 vector", redir_pc, VB + 32'h600);
        idle();
        #1 check("R13 run code", 32'(state_code), 2'b00);
    endtask

    task automatic t_nmi();
        nmi_req = 1; retire = 1; nmi_blmsk = 0; tick();
        check("R4 nmi masked by bl", 32'(redir_vld), 0);
        nmi_blmsk = 1; nxt_pc = 32'h5000; tick();
        check("R4 nmi override", 32'(redir_vld), 1);
        check("R4 nmi vector", redir_pc, VB + 32'h700);
        idle();
    endtask

    task automatic t_break();
        brk_req = 1; exc_reexec = 1; cur_pc = 32'h2000; tick();
        check("R5 break squashed", 32'(redir_vld), 0);
        check("R5 mask unchanged", 32'(sr_imask), 5);
        idle();
        cr_write(2'd0, srw(1, 1, 0, 5));
        brk_req = 1; exc_reexec = 1; cur_pc = 32'h2000; nxt_pc = 32'h2002; tick();
        check("R8 break vector", redir_pc, VB + 32'h100);
        idle();
        do_return("R8 reexec", 32'h2000);
        exc_req = 1; cur_pc = 32'h2100; nxt_pc = 32'h2102; tick();
        check("R8 exc vector", redir_pc, VB + 32'h100);
        idle();
        do_return("R8 completed", 32'h2102);
    endtask

    task automatic t_priority();
        exc_req = 1; nmi_req = 1; irq_req = 1; irq_lvl = 15; retire = 1; nxt_pc = 32'h6000; tick();
        check("R9 exception wins", redir_pc, VB + 32'h100);
        idle(); do_return("R9 a", 32'h6000);
        nmi_req = 1; irq_req = 1; irq_lvl = 15; retire = 1; tick();
        check("R9 nmi over irq", redir_pc, VB + 32'h700);
        idle(); do_return("R9 b", 32'h102);
        brk_req = 1; nmi_req = 1; retire = 1; tick();
        check("R9 break over nmi", redir_pc, VB + 32'h100);
        idle(); do_return("R9 c", 32'h102);
    endtask

    task automatic t_blk_exc();
        exc_req = 1; nxt_pc = 32'h7000; tick();
        idle();
        exc_req = 1; nxt_pc = 32'h7777; cr_wr_en = 1; cr_sel = 3; cr_wr_data = 32'h1111_0000; tick();
        check("R6 reset address", redir_pc, 32'hA000_0000);
        check("R6 redirect", 32'(redir_vld), 1);
        check("R6 no rst_out", 32'(rst_out), 0);
        check("R6 code not reset", 32'(state_code), 0);
        idle();
        do_return("R6 spc kept", 32'h7000);
    endtask

    task automatic t_slot();
        exc_req = 1; nxt_pc = 32'h7100; tick();
        idle(); rte_req = 1; tick();
        idle(); exc_req = 1; tick();
        check("R11 slot flag", 32'(rte_slot_err), 1);
        check("R11 no redirect", 32'(redir_vld), 0);
        idle(); tick();
        check("R11 flag clears", 32'(rte_slot_err), 0);
        retire = 1; tick();
        check("R11 return completes", redir_pc, 32'h7100);
        idle();
        exc_req = 1; tick();
        check("R12 vbr write dropped", redir_pc, VB + 32'h100);
        idle(); do_return("R12 end", 32'h102);
    endtask

    initial begin
        idle();
        t_reset();
        t_irq_block();
        t_level();
        t_low_power();
        t_nmi();
        t_break();
        t_priority();
        t_blk_exc();
        t_slot();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule